// File: doc/BRIEF.md
# SPI Port with Write-One-to-Clear Error Flags

This block is a serial peripheral port that a processor drives through three small registers: a data register, a mode register and a status register. Enabled as master, a write to the data register starts a character of 1 to 8 bits. The character goes out most significant bit first on MOSI, and the same number of bits is gathered from MISO. The serial clock advances one half period for each pulse on `baud_tick`, which comes from a separate rate generator. Enabled as slave, the port loads the last written data byte when its select input goes low. It then presents that byte on MISO and gathers MOSI bits on the rising edges of the incoming SCK. When the select input returns high, the received character is handed to the data register.

Clock polarity and phase are fixed: SCK idles low, data is sampled on the rising edge, and outgoing data changes on the falling edge. The status register holds three sticky flags. The overrun flag marks a data write made while a character was in flight; that write is thrown away. The collision flag marks the select input going active while the port is an enabled master; the transfer is then aborted. The interrupt-pending flag marks the end of a character. Each flag is cleared by writing a one to its bit position.

Top module: `spi_ef_top`

## Requirements
- R1: A write to the data register while a character is in progress (status bit 3 = 1) sets the overrun flag (status bit 0). The written value is discarded, and the character in flight is shifted out unchanged.
- R2: Status bits 0 (overrun), 1 (collision) and 2 (interrupt pending) are cleared only by writing a 1 at their position. Writing 0 leaves them unchanged. Bit 3 reads the busy state, and bits 7:4 read 0.
- R3: While the mode register has enable (bit 0) and master (bit 1) set, a low `ss_n_i` sets the collision flag. Within 4 cycles of the pin change, the transfer is aborted, `sck_o` is low, `mosi_oe` is low and busy reads 0.
- R4: Mode bits 5:3 give the character length. Value 0 means 8 bits, and values 1 to 7 mean that many bits. Data is held in the low bits of the data register.
- R5: As master, a data write when idle starts a character. MOSI carries data bits n-1 down to 0 and changes only while SCK is low. MISO is sampled at each SCK rising edge. SCK toggles once per `baud_tick` and idles low. After the last bit, the data register reads the received bits, right-aligned with zeros above.
- R6: As master with interrupt enable (mode bit 2) set, the interrupt-pending flag is set when a character has finished, and `irq` follows that flag.
- R7: As slave (enable set, master clear), a low `ss_n_i` loads the last written data byte. `miso_o` then presents its bits MSB first, changing after each SCK falling edge, and `miso_oe` is high only while selected. `mosi_i` is sampled on SCK rising edges. When `ss_n_i` rises, the data register takes the received bits and, if interrupts are enabled, the interrupt-pending flag is set.
- R8: With interrupt enable clear, a finished character leaves the interrupt-pending flag at 0.
- R9: After reset, all three registers read 0, and `sck_o`, `mosi_oe`, `miso_oe` and `irq` are low.
- R10: `reg_sel` selects the register: 0 for data, 1 for mode, 2 for status. Reading select value 3 returns 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| baud_tick | input | 1 | One-cycle pulse per SCK half period |
| sck_o | output | 1 | Serial clock driven as master |
| mosi_o | output | 1 | Serial data out as master |
| mosi_oe | output | 1 | MOSI drive enable |
| miso_i | input | 1 | Serial data in as master |
| sck_i | input | 1 | Serial clock received as slave |
| mosi_i | input | 1 | Serial data in as slave |
| ss_n_i | input | 1 | Active-low select input |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | MISO drive enable |
| irq | output | 1 | Interrupt request, follows the pending flag |

## Verification
Errors in the bit counter or the latched length appear on the pins within one character. Too few or too many SCK pulses, a shifted MOSI pattern, or a received value with bits in the wrong place are all visible before busy falls. A flag held in the wrong state is seen at the next status read, and a missed or false collision is seen within a few cycles of the select pin moving. Random lengths, data and MISO patterns are mixed with directed overrun, collision and slave transfers, so each length code and each flag path is observed at the ports.

// File: rtl/spi_ef_pkg.sv
package spi_ef_pkg;
   localparam logic [1:0] SEL_DATA = 2'd0;
   localparam logic [1:0] SEL_MODE = 2'd1;
   localparam logic [1:0] SEL_STAT = 2'd2;

   typedef struct packed {
      logic [1:0] spare;
      logic [2:0] len;
      logic       irq_en;
      logic       master;
      logic       en;
   } mode_t;
endpackage

// File: rtl/spi_ef_sync.sv
module spi_ef_sync #(
   parameter int          W      = 3,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RSTV  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   initial assert (STAGES >= 2) else $error("spi_ef_sync: STAGES below 2");

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st[0] <= RSTV;
      else        st[0] <= d;

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) st[s] <= RSTV;
         else        st[s] <= st[s-1];
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_ef_master.sv
module spi_ef_master #(
   parameter int DW = 8,
   localparam int LW = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] tx,
   input  logic [LW-1:0] nbits,
   input  logic          tick,
   input  logic          miso,
   input  logic          fault,
   output logic          sck,
   output logic          mosi,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rx
);
   logic [DW-1:0] sh;
   logic [LW-1:0] cnt, nb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0; rx <= '0; cnt <= '0; nb_q <= '0;
         busy <= 1'b0; sck <= 1'b0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (fault) begin
            busy <= 1'b0; sck <= 1'b0; cnt <= '0;
         end else if (go) begin
            sh   <= tx << (DW - int'(nbits));
            rx   <= '0;
            cnt  <= '0;
            nb_q <= nbits;
            busy <= 1'b1;
            sck  <= 1'b0;
         end else if (busy && tick) begin
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[DW-2:0], miso};
               cnt <= cnt + 1'b1;
            end else begin
               sck <= 1'b0;
               if (cnt == nb_q) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  sh <= sh << 1;
               end
            end
         end
      end
   end

   assign mosi = sh[DW-1];

   // R3
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!busy && !sck));
   // R5
   bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt <= nb_q));
   // R5
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);
endmodule

// File: rtl/spi_ef_slave.sv
module spi_ef_slave #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          sck_s,
   input  logic          mosi_s,
   input  logic [DW-1:0] tx,
   input  logic [$clog2(DW+1)-1:0] nbits,
   output logic          miso,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rx
);
   logic [DW-1:0] sh;
   logic          sel_q, sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0; rx <= '0; sel_q <= 1'b0; sck_q <= 1'b0;
         busy <= 1'b0; done <= 1'b0;
      end else begin
         sel_q <= sel;
         sck_q <= sck_s;
         done  <= 1'b0;
         if (sel && !sel_q) begin
            sh   <= tx << (DW - int'(nbits));
            rx   <= '0;
            busy <= 1'b1;
         end else if (busy && !sel) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else if (busy) begin
            if (sck_s && !sck_q)      rx <= {rx[DW-2:0], mosi_s};
            else if (!sck_s && sck_q) sh <= sh << 1;
         end
      end
   end

   assign miso = sh[DW-1];

   // R7
   slave_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sel) |=> (done && !busy));
endmodule

// File: rtl/spi_ef_regs.sv
module spi_ef_regs
   import spi_ef_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic          wr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   input  logic          busy,
   input  logic          fault,
   input  logic          mdone,
   input  logic [DW-1:0] mrx,
   input  logic          sdone,
   input  logic [DW-1:0] srx,
   output mode_t         mode,
   output logic [DW-1:0] tx_q,
   output logic          go,
   output logic          pend
);
   logic          ovr, col;
   logic [DW-1:0] rx_q;
   logic dat_wr, mod_wr, st_wr;
   wire  unused_hi = ^wdata[7:3];

   assign dat_wr = wr && (sel == SEL_DATA);
   assign mod_wr = wr && (sel == SEL_MODE);
   assign st_wr  = wr && (sel == SEL_STAT);
   assign go     = dat_wr && !busy && mode.en && mode.master && !fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0; tx_q <= '0; rx_q <= '0;
         ovr <= 1'b0; col <= 1'b0; pend <= 1'b0;
      end else begin
         if (mod_wr)            mode <= mode_t'(wdata);
         if (dat_wr && !busy)   tx_q <= wdata[DW-1:0];
         if (mdone)             rx_q <= mrx;
         else if (sdone)        rx_q <= srx;

         if (dat_wr && busy)         ovr <= 1'b1;
         else if (st_wr && wdata[0]) ovr <= 1'b0;

         if (fault)                  col <= 1'b1;
         else if (st_wr && wdata[1]) col <= 1'b0;

         if ((mdone || sdone) && mode.irq_en) pend <= 1'b1;
         else if (st_wr && wdata[2])          pend <= 1'b0;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: rdata = 8'(rx_q);
         SEL_MODE: rdata = mode;
         SEL_STAT: rdata = {4'b0, busy, pend, col, ovr};
         default:  rdata = 8'h00;
      endcase
   end

   // R1
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && busy) |=> ovr);
   // R2
   col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && wdata[1] && !fault) |=> !col);
   // R8
   pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(mode.irq_en));
endmodule

// File: rtl/spi_ef_top.sv
module spi_ef_top
   import spi_ef_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LW         = $clog2(DW + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_sel,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       baud_tick,
   output logic       sck_o,
   output logic       mosi_o,
   output logic       mosi_oe,
   input  logic       miso_i,
   input  logic       sck_i,
   input  logic       mosi_i,
   input  logic       ss_n_i,
   output logic       miso_o,
   output logic       miso_oe,
   output logic       irq
);
   initial assert (DW >= 2 && DW <= 8) else $error("spi_ef_top: DW must be 2..8");

   mode_t         mode;
   logic [DW-1:0] tx_q, mrx, srx;
   logic [LW-1:0] nbits;
   logic          go, mbusy, sbusy, mdone, sdone, fault, slv_sel;
   logic          sck_s, mosi_s, ss_n_s;

   spi_ef_sync #(.W(3), .STAGES(SYNC_STAGES), .RSTV(3'b100)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ss_n_i, sck_i, mosi_i}), .q({ss_n_s, sck_s, mosi_s}));

   assign nbits   = (mode.len == 3'd0 || int'(mode.len) > DW) ? LW'(DW) : LW'(mode.len);
   assign fault   = mode.en && mode.master && !ss_n_s;
   assign slv_sel = mode.en && !mode.master && !ss_n_s;

   spi_ef_regs #(.DW(DW)) i_regs (
      .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(mbusy || sbusy), .fault(fault),
      .mdone(mdone), .mrx(mrx), .sdone(sdone), .srx(srx),
      .mode(mode), .tx_q(tx_q), .go(go), .pend(irq));

   spi_ef_master #(.DW(DW)) i_mst (
      .clk(clk), .rst_n(rst_n), .go(go), .tx(reg_wdata[DW-1:0]), .nbits(nbits),
      .tick(baud_tick), .miso(miso_i), .fault(fault), .sck(sck_o),
      .mosi(mosi_o), .busy(mbusy), .done(mdone), .rx(mrx));

   spi_ef_slave #(.DW(DW)) i_slv (
      .clk(clk), .rst_n(rst_n), .sel(slv_sel), .sck_s(sck_s), .mosi_s(mosi_s),
      .tx(tx_q), .nbits(nbits), .miso(miso_o), .busy(sbusy), .done(sdone),
      .rx(srx));

   assign mosi_oe = mode.en && mode.master && mbusy;
   assign miso_oe = slv_sel;

   // R3
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!mosi_oe && !sck_o));
endmodule

// File: tb/test_spi_ef_top.sv
module test_spi_ef_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] reg_sel = '0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic baud_tick = 1'b0;
   logic sck_o, mosi_o, mosi_oe, miso_i, miso_o, miso_oe, irq;
   logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

   int total = 0, bad = 0;
   bit finished = 0;

   int nb = 8, rise_cnt = 0, mon_bad = 0;
   logic [7:0] pat = '0, cap = '0;
   logic prev_sck = 1'b0, prev_mosi = 1'b0, mon_clr = 1'b0;

   spi_ef_top i_spi_ef_top (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
      .sck_o(sck_o), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
      .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o),
      .miso_oe(miso_oe), .irq(irq));

   always #5 clk = ~clk;

   initial forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
   end

   // external slave model for master transfers
   assign miso_i = (rise_cnt < nb) ? pat[nb-1-rise_cnt] : 1'b0;

   always @(negedge clk) begin
      if (mon_clr) begin
         rise_cnt <= 0; cap <= '0;
      end else if (sck_o && !prev_sck) begin
         rise_cnt <= rise_cnt + 1;
         cap <= {cap[6:0], mosi_o};
      end
      if (sck_o && prev_sck && mosi_o != prev_mosi) mon_bad <= mon_bad + 1;
      prev_sck  <= sck_o;
      prev_mosi <= mosi_o;
   end

   function automatic logic [7:0] lmask(int n);
      return 8'((9'd1 << n) - 9'd1);
   endfunction

   function automatic logic [2:0] lcode(int n);
      return (n == 8) ? 3'd0 : 3'(n);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] s, logic [7:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      reg_sel = s;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int i = 0; i < 600; i++) begin
         rd(2, st);
         if (!st[3]) break;
      end
   endtask

   task automatic master_xfer(int n, logic [7:0] tx, logic [7:0] p, bit ie);
      logic [7:0] v;
      wr(1, {2'b00, lcode(n), ie, 1'b1, 1'b1});
      nb = n; pat = p;
      @(negedge clk); mon_clr = 1'b1;
      @(negedge clk); mon_clr = 1'b0;
      wr(0, tx);
      wait_idle();
      repeat (2) @(negedge clk);
      chk((cap & lmask(n)) == (tx & lmask(n)), "R5 mosi bits", int'(cap & lmask(n)), int'(tx & lmask(n)));
      rd(0, v);
      chk(v == (p & lmask(n)), "R4 rx data", int'(v), int'(p & lmask(n)));
      rd(2, v);
      if (ie) begin
         chk(v[2] && irq, "R6 irq pending", int'(v), 4);
         wr(2, 8'h04);
         rd(2, v);
         chk(!v[2] && !irq, "R2 irq clear", int'(v), 0);
      end else begin
         chk(!v[2] && !irq, "R8 no pending", int'(v), 0);
      end
   endtask

   task automatic slave_xfer(int n, logic [7:0] tx, logic [7:0] mp);
      logic [7:0] v, sc;
      sc = '0;
      wr(1, {2'b00, lcode(n), 1'b1, 1'b0, 1'b1});
      wr(0, tx);
      #1 chk(!miso_oe, "R7 oe idle", int'(miso_oe), 0);
      ss_n_i = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         mosi_i = mp[n-1-i];
         repeat (8) @(negedge clk);
         sc = {sc[6:0], miso_o};
         if (!miso_oe) sc = 8'hEE;
         sck_i = 1'b1;
         repeat (8) @(negedge clk);
         sck_i = 1'b0;
         repeat (8) @(negedge clk);
      end
      ss_n_i = 1'b1;
      repeat (8) @(negedge clk);
      chk((sc & lmask(n)) == (tx & lmask(n)), "R7 miso bits", int'(sc & lmask(n)), int'(tx & lmask(n)));
      rd(0, v);
      chk(v == (mp & lmask(n)), "R7 slave rx", int'(v), int'(mp & lmask(n)));
      rd(2, v);
      chk(v[2] && irq, "R7 slave irq", int'(v), 4);
      wr(2, 8'h04);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      rd(0, v); chk(v == 0, "R9 data reset", int'(v), 0);
      rd(1, v); chk(v == 0, "R9 mode reset", int'(v), 0);
      rd(2, v); chk(v == 0, "R9 status reset", int'(v), 0);
      chk(!sck_o && !mosi_oe && !miso_oe && !irq, "R9 pins idle",
          int'({sck_o, mosi_oe, miso_oe, irq}), 0);
      rd(3, v); chk(v == 0, "R10 unused select", int'(v), 0);
      wr(1, 8'h2B);
      rd(1, v); chk(v == 8'h2B, "R10 mode readback", int'(v), 8'h2B);

      // directed lengths
      master_xfer(8, 8'hA5, 8'h3C, 1'b1);
      master_xfer(1, 8'h01, 8'h01, 1'b1);
      master_xfer(3, 8'hF6, 8'h05, 1'b0);
      // random
      for (int k = 0; k < 8; k++)
         master_xfer(int'($urandom_range(8, 1)), 8'($urandom), 8'($urandom), 1'($urandom));
      chk(mon_bad == 0, "R5 mosi stable high", mon_bad, 0);

      // R1 overrun
      wr(1, {2'b00, 3'd0, 1'b0, 1'b1, 1'b1});
      nb = 8; pat = 8'h00;
      @(negedge clk); mon_clr = 1'b1;
      @(negedge clk); mon_clr = 1'b0;
      wr(0, 8'hC3);
      repeat (10) @(negedge clk);
      wr(0, 8'h18);
      rd(2, v); chk(v[0] && v[3], "R1 overrun set", int'(v), 9);
      wait_idle();
      repeat (2) @(negedge clk);
      chk(cap == 8'hC3, "R1 transfer intact", int'(cap), 8'hC3);
      wr(2, 8'h00);
      rd(2, v); chk(v[0], "R2 write zero keeps", int'(v), 1);
      wr(2, 8'h01);
      rd(2, v); chk(v == 0, "R2 w1c overrun", int'(v), 0);

      // R3 mode fault
      wr(0, 8'hFF);
      repeat (12) @(negedge clk);
      ss_n_i = 1'b0;
      repeat (4) @(negedge clk);
      rd(2, v);
      chk(v[1] && !v[3], "R3 collision flag", int'(v), 2);
      chk(!sck_o && !mosi_oe, "R3 pins idle", int'({sck_o, mosi_oe}), 0);
      ss_n_i = 1'b1;
      repeat (5) @(negedge clk);
      wr(2, 8'h05);
      rd(2, v); chk(v[1], "R2 other bits keep col", int'(v), 2);
      wr(2, 8'h02);
      rd(2, v); chk(v == 0, "R2 w1c collision", int'(v), 0);

      // slave
      slave_xfer(8, 8'h96, 8'h5A);
      slave_xfer(2, 8'h02, 8'h01);
      for (int k = 0; k < 3; k++)
         slave_xfer(int'($urandom_range(8, 1)), 8'($urandom), 8'($urandom));

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule